// File: doc/BRIEF.md
# Packed SIMD Right-Shift Unit

This block is a 64-bit packed right-shift datapath for a SIMD execution pipe. Each operation carries an opcode byte (the escape prefix already removed), the 3-bit reg field of the following ModRM byte, a 64-bit source operand and a 64-bit count operand. The unit decodes the opcode into a lane width (16, 32 or 64 bits) and a shift kind (logical or arithmetic). It shifts every lane of the source right by the same count. One clock after the request it presents the packed result with a valid strobe.

Two count sources exist. Register forms take the count from the full 64-bit count operand. Immediate forms take only its low byte, zero-extended. Each lane compares the whole effective count against its width. An oversized count therefore never wraps modulo the lane width: it saturates the lane to zero for logical shifts or to copies of the sign bit for arithmetic shifts. An opcode or reg-field combination outside the supported set is flagged as illegal rather than executed.

Top module: `vec_rshift_unit`

## Requirements
- R1: The 64-bit source is split into four 16-bit lanes (bits 15:0, 31:16, 47:32, 63:48), two 32-bit lanes (31:0, 63:32) or one 64-bit lane. Every lane is shifted independently by the same count, and no bit crosses a lane boundary.
- R2: A logical shift fills the vacated high-order bits of each lane with zeros.
- R3: An arithmetic shift fills the vacated high-order bits of each lane with that lane's original most significant bit.
- R4: For a logical shift, an effective count of at least the lane width (16, 32 or 64) clears the whole result. All 64 count bits are examined, so a count of 2^32+1 clears the result rather than shifting by one.
- R5: For an arithmetic shift, an effective count of at least the lane width (16 or 32) turns every lane into copies of its original sign bit, including counts of 255 and counts with only bit 63 set.
- R6: For the immediate forms the effective count is cnt[7:0] zero-extended, and cnt[63:8] has no effect on the result.
- R7: Opcode map. D1 is logical words, D2 logical doublewords, D3 logical quadword, E1 arithmetic words, E2 arithmetic doublewords, for all reg-field values. The immediate forms are 71 (words), 72 (doublewords) and 73 (quadword); with them, reg field 2 selects logical and reg field 4 selects arithmetic.
- R8: An unlisted opcode byte, an immediate form whose reg field is neither 2 nor 4, or opcode 73 with reg field 4 (arithmetic quadword) sets op_illegal together with out_valid, and res reads zero.
- R9: out_valid is high in exactly the cycle after in_valid was sampled high. While in_valid is low, res and op_illegal hold their values.
- R10: Synchronous active-high reset clears out_valid, op_illegal and res.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; operands are sampled on this cycle |
| opc_byte | input | 8 | Opcode byte following the escape prefix |
| modrm_reg | input | 3 | Reg field of the ModRM byte (kind select for immediate forms) |
| src | input | 64 | Packed source operand |
| cnt | input | 64 | Count operand; only bits 7:0 are used by immediate forms |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| res | output | 64 | Packed shifted result |
| op_illegal | output | 1 | Request did not decode to a supported operation |

## Verification
Two functions can fall in the same cycle: immediate-count truncation and oversize saturation. Both act on one count value. The bench provokes this by sending a count whose low byte is small while its upper bits are set, issuing it once through a register form and once through an immediate form on consecutive cycles. The register form must saturate and the immediate form must shift by the low byte alone. Each result is judged against a per-lane behavioural model that shifts bit by bit from the requirements, alongside hand-computed literals for two patterns.

// File: rtl/vrs_pkg.sv
package vrs_pkg;

  typedef enum logic [1:0] {
    LW_16 = 2'd0,
    LW_32 = 2'd1,
    LW_64 = 2'd2
  } lane_sel_e;

  typedef struct packed {
    lane_sel_e width;
    logic      arith;
    logic      imm;
    logic      illegal;
  } shop_t;

endpackage

// File: rtl/vrs_decode.sv
module vrs_decode
  import vrs_pkg::*;
(
  input  logic [7:0] opc_byte,
  input  logic [2:0] modrm_reg,
  output shop_t      op
);

  localparam logic [2:0] REG_LOGIC = 3'd2;
  localparam logic [2:0] REG_ARITH = 3'd4;

  always_comb begin
    op = '{width: LW_16, arith: 1'b0, imm: 1'b0, illegal: 1'b0};
    unique case (opc_byte)
      8'hD1: op.width = LW_16;
      8'hD2: op.width = LW_32;
      8'hD3: op.width = LW_64;
      8'hE1: begin op.width = LW_16; op.arith = 1'b1; end
      8'hE2: begin op.width = LW_32; op.arith = 1'b1; end
      8'h71, 8'h72, 8'h73: begin
        op.imm   = 1'b1;
        op.width = (opc_byte == 8'h71) ? LW_16 :
                   (opc_byte == 8'h72) ? LW_32 : LW_64;
        if (modrm_reg == REG_LOGIC) begin
          op.arith = 1'b0;
        end else if (modrm_reg == REG_ARITH && opc_byte != 8'h73) begin
          op.arith = 1'b1;
        end else begin
          op.illegal = 1'b1;
        end
      end
      default: op.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/vrs_lane_shift.sv
module vrs_lane_shift #(
  parameter int LANE_W = 16,
  parameter int CNT_W  = 64
) (
  input  logic [LANE_W-1:0] lane_in,
  input  logic [CNT_W-1:0]  amount,
  input  logic              arith,
  output logic [LANE_W-1:0] lane_out
);

  localparam int IDX_W = $clog2(LANE_W);

  logic                     sign_b;
  logic                     over;
  logic [IDX_W-1:0]         sh;
  logic signed [LANE_W-1:0] sra_v;
  logic [LANE_W-1:0]        srl_v;

  assign sign_b = arith & lane_in[LANE_W-1];
  // any bit at or above the lane index width means count >= LANE_W
  assign over   = |amount[CNT_W-1:IDX_W];
  assign sh     = amount[IDX_W-1:0];
  assign sra_v  = $signed(lane_in) >>> sh;
  assign srl_v  = lane_in >> sh;

  always_comb begin
    if (over)       lane_out = {LANE_W{sign_b}};
    else if (arith) lane_out = sra_v;
    else            lane_out = srl_v;
  end

endmodule

// File: rtl/vec_rshift_unit.sv
module vec_rshift_unit
  import vrs_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 64,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        opc_byte,
  input  logic [2:0]        modrm_reg,
  input  logic [DATA_W-1:0] src,
  input  logic [CNT_W-1:0]  cnt,
  output logic              out_valid,
  output logic [DATA_W-1:0] res,
  output logic              op_illegal
);

  localparam int N16 = DATA_W / 16;
  localparam int N32 = DATA_W / 32;
  localparam int N64 = DATA_W / 64;

  shop_t              op;
  logic [CNT_W-1:0]   eff_cnt;
  logic [DATA_W-1:0]  r16, r32, r64;
  logic [DATA_W-1:0]  res_nxt;

  vrs_decode u_dec (
    .opc_byte  (opc_byte),
    .modrm_reg (modrm_reg),
    .op        (op)
  );

  assign eff_cnt = op.imm ? {{(CNT_W-IMM_W){1'b0}}, cnt[IMM_W-1:0]} : cnt;

  for (genvar g = 0; g < N16; g++) begin : g_w16
    vrs_lane_shift #(.LANE_W(16), .CNT_W(CNT_W)) u_ls (
      .lane_in  (src[g*16 +: 16]),
      .amount   (eff_cnt),
      .arith    (op.arith),
      .lane_out (r16[g*16 +: 16])
    );
  end

  for (genvar g = 0; g < N32; g++) begin : g_w32
    vrs_lane_shift #(.LANE_W(32), .CNT_W(CNT_W)) u_ls (
      .lane_in  (src[g*32 +: 32]),
      .amount   (eff_cnt),
      .arith    (op.arith),
      .lane_out (r32[g*32 +: 32])
    );
  end

  for (genvar g = 0; g < N64; g++) begin : g_w64
    vrs_lane_shift #(.LANE_W(64), .CNT_W(CNT_W)) u_ls (
      .lane_in  (src[g*64 +: 64]),
      .amount   (eff_cnt),
      .arith    (1'b0),
      .lane_out (r64[g*64 +: 64])
    );
  end

  always_comb begin
    if (op.illegal) begin
      res_nxt = '0;
    end else begin
      unique case (op.width)
        LW_16:   res_nxt = r16;
        LW_32:   res_nxt = r32;
        default: res_nxt = r64;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      op_illegal <= 1'b0;
      res        <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        op_illegal <= op.illegal;
        res        <= res_nxt;
      end
    end
  end

  // R9
  valid_pipe_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R9
  idle_pipe_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R9
  res_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(res) && $stable(op_illegal)));

  // R8
  illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
    op_illegal |-> (res == '0));

  // R8
  sra_qword_rej_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opc_byte == 8'h73 && modrm_reg == 3'd4) |=> op_illegal);

  // R4
  qword_over_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opc_byte == 8'hD3 && (|cnt[CNT_W-1:6])) |=> (res == '0));

endmodule

// File: tb/vec_rshift_unit_tb.sv
module vec_rshift_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [7:0]  opc_byte;
  logic [2:0]  modrm_reg;
  logic [63:0] src;
  logic [63:0] cnt;
  logic        out_valid;
  logic [63:0] res;
  logic        op_illegal;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_rshift_unit u_dut (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .opc_byte   (opc_byte),
    .modrm_reg  (modrm_reg),
    .src        (src),
    .cnt        (cnt),
    .out_valid  (out_valid),
    .res        (res),
    .op_illegal (op_illegal)
  );

  // stimulus table: opcode, reg field, source, count, requirement number
  localparam logic [7:0] T_OPC [NV] = '{
    8'hD1, 8'hD2, 8'hD3, 8'hE1, 8'hE2, 8'hD1, 8'hD2, 8'hE1, 8'hE2,
    8'h71, 8'h72, 8'h73, 8'hD3, 8'hE1, 8'h73, 8'h71, 8'hD4, 8'h72};
  localparam logic [2:0] T_REG [NV] = '{
    3'd0, 3'd7, 3'd1, 3'd0, 3'd3, 3'd0, 3'd0, 3'd0, 3'd0,
    3'd2, 3'd4, 3'd2, 3'd0, 3'd5, 3'd4, 3'd6, 3'd2, 3'd2};
  localparam logic [63:0] T_SRC [NV] = '{
    64'h8000_7FFF_1234_F00F,  // R1 R2 words logical by 4
    64'hF000_0001_8000_0000,  // R2 dwords logical by 31
    64'h8000_0000_0000_0001,  // R2 qword logical by 63
    64'h8000_7FFF_FFFF_0001,  // R3 words arithmetic by 15
    64'h8765_4321_0FED_CBA9,  // R3 dwords arithmetic by 0
    64'hFFFF_8000_7FFF_0001,  // R4 words logical by 16
    64'hFFFF_FFFF_8000_0001,  // R4 dwords logical by 2^32+1
    64'h8001_7FFF_C000_0123,  // R5 words arithmetic by 255
    64'h8000_0000_7FFF_FFFF,  // R5 dwords arithmetic by bit 63 only
    64'hF00F_0FF0_8001_7FFE,  // R6 imm words logical, low byte 3
    64'h8000_0001_7FFF_FFFF,  // R6 imm dwords arithmetic, low byte 32
    64'hC000_0000_0000_0003,  // R6 imm qword logical, low byte 1
    64'hFFFF_FFFF_FFFF_FFFF,  // R4 qword logical by 64
    64'h8001_4000_FFFE_0002,  // R7 words arithmetic by 1
    64'hFFFF_FFFF_FFFF_FFFF,  // R8 arithmetic quadword rejected
    64'h1234_5678_9ABC_DEF0,  // R8 bad reg field
    64'h1234_5678_9ABC_DEF0,  // R8 unlisted opcode
    64'hFFFF_0000_8000_0000}; // R7 imm dwords logical by 31
  localparam logic [63:0] T_CNT [NV] = '{
    64'd4, 64'd31, 64'd63, 64'd15, 64'd0, 64'd16,
    64'h0000_0001_0000_0001, 64'd255, 64'h8000_0000_0000_0000,
    64'hFFFF_FFFF_FFFF_FF03, 64'h1234_0000_0000_0020,
    64'h0000_0000_0000_0101, 64'd64, 64'd1, 64'd1, 64'd1, 64'd1,
    64'hFF00_0000_0000_001F};
  localparam int T_REQ [NV] = '{1, 2, 2, 3, 3, 4, 4, 5, 5, 6, 6, 6, 4, 7, 8, 8, 8, 7};

  // behavioural per-lane model built from the requirements
  function automatic logic [63:0] model(input logic [7:0] opc, input logic [2:0] rf,
                                        input logic [63:0] s, input logic [63:0] c_in,
                                        output logic bad);
    int          w;
    bit          ar;
    bit          immf;
    logic [63:0] c;
    logic        fill;
    logic [63:0] r;
    bad = 1'b0; w = 16; ar = 1'b0; immf = 1'b0; r = '0;
    case (opc)
      8'hD1: w = 16;
      8'hD2: w = 32;
      8'hD3: w = 64;
      8'hE1: begin w = 16; ar = 1'b1; end
      8'hE2: begin w = 32; ar = 1'b1; end
      8'h71, 8'h72, 8'h73: begin
        immf = 1'b1;
        w = (opc == 8'h71) ? 16 : (opc == 8'h72) ? 32 : 64;
        if (rf == 3'd2) ar = 1'b0;
        else if (rf == 3'd4 && opc != 8'h73) ar = 1'b1;
        else bad = 1'b1;
      end
      default: bad = 1'b1;
    endcase
    if (bad) return 64'd0;
    c = immf ? {56'd0, c_in[7:0]} : c_in;
    for (int l = 0; l < 64 / w; l++) begin
      fill = ar & s[l*w + w - 1];
      for (int b = 0; b < w; b++) begin
        if (c >= 64'(w) || (64'(b) + c) >= 64'(w)) r[l*w + b] = fill;
        else r[l*w + b] = s[l*w + b + int'(c)];
      end
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] o, input logic [2:0] r,
                       input logic [63:0] s, input logic [63:0] c);
    in_valid = 1'b1; opc_byte = o; modrm_reg = r; src = s; cnt = c;
  endtask

  task automatic idle();
    in_valid = 1'b0; opc_byte = 8'h00; modrm_reg = 3'd0; src = '0; cnt = '0;
  endtask

  task automatic check_result(input string tag, input logic [7:0] o, input logic [2:0] r,
                              input logic [63:0] s, input logic [63:0] c);
    logic [63:0] e;
    logic        b;
    e = model(o, r, s, c, b);
    chk({tag, " out_valid"}, {63'd0, out_valid}, 64'd1);
    chk({tag, " op_illegal"}, {63'd0, op_illegal}, {63'd0, b});
    chk({tag, " res"}, res, e);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    idle();
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 reset out_valid", {63'd0, out_valid}, 64'd0);
    chk("R10 reset op_illegal", {63'd0, op_illegal}, 64'd0);
    chk("R10 reset res", res, 64'd0);
    rst = 1'b0;
    @(negedge clk);

    // table walk
    for (int i = 0; i < NV; i++) begin
      drive(T_OPC[i], T_REG[i], T_SRC[i], T_CNT[i]);
      @(negedge clk);
      idle();
      check_result($sformatf("R%0d vec %0d", T_REQ[i], i), T_OPC[i], T_REG[i], T_SRC[i], T_CNT[i]);
      @(negedge clk);
    end

    // R2 hand-computed words logical by 4
    drive(8'hD1, 3'd0, 64'h8000_7FFF_1234_F00F, 64'd4);
    @(negedge clk); idle();
    chk("R2 literal words logical", res, 64'h0800_07FF_0123_0F00);
    @(negedge clk);

    // R3 hand-computed words arithmetic by 4
    drive(8'hE1, 3'd0, 64'h8000_7FFF_1234_F00F, 64'd4);
    @(negedge clk); idle();
    chk("R3 literal words arithmetic", res, 64'hF800_07FF_0123_FF00);

    // R9: idle cycles hold result, out_valid low
    @(negedge clk);
    chk("R9 idle out_valid", {63'd0, out_valid}, 64'd0);
    src = 64'hDEAD_BEEF_DEAD_BEEF; cnt = 64'd1; opc_byte = 8'hD1;
    @(negedge clk);
    chk("R9 hold res", res, 64'hF800_07FF_0123_FF00);

    // R6 with R4 on consecutive cycles: same count, register form then immediate form
    drive(8'hD1, 3'd0, 64'h8000_7FFF_1234_F00F, 64'h0000_0100_0000_0002);
    @(negedge clk);
    chk("R4 register form huge count", res, 64'd0);
    drive(8'h71, 3'd2, 64'h8000_7FFF_1234_F00F, 64'h0000_0100_0000_0002);
    @(negedge clk);
    idle();
    chk("R6 immediate form low byte 2", res, 64'h2000_1FFF_048D_3C03);
    chk("R9 back-to-back out_valid", {63'd0, out_valid}, 64'd1);

    // R5 imm words arithmetic with low byte 16
    drive(8'h71, 3'd4, 64'h8000_7FFF_FFFF_0001, 64'h0000_0000_0000_0010);
    @(negedge clk); idle();
    chk("R5 imm words arithmetic count 16", res, 64'hFFFF_0000_FFFF_0000);
    @(negedge clk);

    // R10: reset clears an outstanding result
    drive(8'hD3, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; idle();
    chk("R10 reset during request out_valid", {63'd0, out_valid}, 64'd0);
    chk("R10 reset during request res", res, 64'd0);
    @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule